// File: doc/BRIEF.md
# Group Index Tree Walker

The block maps the upper bits of an incoming key to a group handle by walking a sparse lookup tree in which every node has 2^k children. The tree lives in a single-port on-chip table. The key is cut into fields of k bits each. The walk uses the most significant field first, and each field selects one child at one tree level. A walk needs one table lookup per level, and it stops early when it reaches a leaf or an empty entry.

Each non-leaf entry stores a base index: the table address of its first child. That child and its siblings sit at consecutive addresses, so a child's address is the base index plus the field value. The root has an implied base index of zero, so the first lookup reads the address equal to the top field.

When the walk reaches a leaf, the block reports a hit with the handle stored there. When it reaches an empty entry, it reports a miss, together with the address of that entry and the level it sits at, so that a controller can install a group or a new node there. That controller uses the write port of the block. Each lookup takes one table read cycle followed by one decode cycle. A busy output holds off new keys until the result is out.

Top module: `group_tree_walker`

## Requirements
- R1: After a synchronous active-low reset, busy, hit and miss are low and group_id, miss_addr and miss_level are zero.
- R2: A key is taken in a cycle where key_valid is high and busy is low. From the next cycle, busy stays high until the cycle the result appears. A key_valid that arrives while busy is high is dropped and never produces a result.
- R3: Level j (0 is the most significant field) uses key bits [KEY_W-1-j*FIELD_W -: FIELD_W]. Level 0 reads the table address equal to that field. Every deeper level reads the parent's base index plus its field, modulo the table size.
- R4: An entry is {kind[1:0], payload}. The kind codes are:
  - 2'b01: internal node. The low ADDR_W bits of the payload are its base index.
  - 2'b10: leaf. The payload is the group handle.
  - 2'b11 (the all-ones no-match tag) and 2'b00: empty.
- R5: A leaf reached at any level ends the walk. It gives a one-cycle hit pulse, with group_id equal to the leaf payload.
- R6: An empty entry ends the walk. It gives a one-cycle miss pulse, with miss_addr set to that entry's table address and miss_level set to its level.
- R7: An internal node at the last level ends the walk as a miss, reporting that entry's address and level.
- R8: A walk that reads L entries puts its result out 2*L clock edges after the accept edge. busy falls in that same cycle.
- R9: With wr_en high and busy low, {wr_kind, wr_payload} is written to wr_addr, and the next walk sees it. A write requested while busy is high is dropped.
- R10: hit and miss are never high together, and each pulse lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_valid | input | 1 | Key offered this cycle |
| key | input | KEY_W | Key whose upper bits select the group |
| busy | output | 1 | Walk in progress; keys and writes are refused |
| hit | output | 1 | One-cycle pulse: a leaf was found |
| group_id | output | PAY_W | Handle held in the leaf found |
| miss | output | 1 | One-cycle pulse: the walk ended on an empty or dead-end entry |
| miss_addr | output | ADDR_W | Table address of the entry that ended the missed walk |
| miss_level | output | LVL_W | Tree level of that entry |
| wr_en | input | 1 | Write one table entry |
| wr_addr | input | ADDR_W | Entry address to write |
| wr_kind | input | 2 | Kind code of the entry written |
| wr_payload | input | PAY_W | Base index or group handle written |

## Verification
A walk that reads L entries gives its hit or miss pulse exactly 2*L edges after the accept edge, so the result takes between 2 and 8 cycles with the default four levels. The bench drives every input half a cycle before the edge that takes it. It then counts negative edges from the accept edge up to the first hit or miss, and compares that count with twice the number of lookups that its own tree model predicts. At every negative edge before the result it also checks that busy is high. Outputs are sampled only at negative edges. The result fields are compared in the pulse cycle, and the cycle after the pulse is checked again to confirm the pulse has ended.

// File: rtl/walk_pkg.sv
// Shared definitions for the group tree walker.
// Assumes every table entry is {kind, payload}, with kind two bits wide.
package walk_pkg;
    typedef enum logic [1:0] {
        ENT_VOID = 2'b00,
        ENT_NODE = 2'b01,
        ENT_LEAF = 2'b10,
        ENT_NONE = 2'b11
    } ent_kind_e;
endpackage

// File: rtl/walk_table_ram.sv
// Single-port synchronous table that holds the tree entries.
// Assumes one access per cycle. A write returns no read data. Contents are not reset.
module walk_table_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // One access per cycle: write the entry, or register the entry read.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end else begin
                rdata <= mem[addr];
            end
        end
    end
endmodule

// File: rtl/walk_step.sv
// Child address for one tree level: base plus the key field of that level.
// Assumes KEY_W is a multiple of FIELD_W. The sum wraps at the table size.
module walk_step #(
    parameter int KEY_W   = 8,
    parameter int FIELD_W = 2,
    parameter int ADDR_W  = 8,
    parameter int LEVELS  = KEY_W / FIELD_W,
    parameter int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic [KEY_W-1:0]  key,
    input  logic [LVL_W-1:0]  level,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] addr
);
    logic [FIELD_W-1:0] fields [LEVELS];

    // Slice the key into fields; the most significant field is level 0.
    for (genvar g = 0; g < LEVELS; g++) begin : g_field
        assign fields[g] = key[KEY_W-1-g*FIELD_W -: FIELD_W];
    end

    // Add the field picked by the level to the base index.
    assign addr = base + ADDR_W'(fields[level]);
endmodule

// File: rtl/walk_ctrl.sv
// Walk sequencer: take a key, alternate read and decode cycles, report the result.
// Assumes the table returns data one cycle after a read. Writes are taken only when idle.
module walk_ctrl #(
    parameter int KEY_W   = 8,
    parameter int FIELD_W = 2,
    parameter int ADDR_W  = 8,
    parameter int PAY_W   = 12,
    parameter int LEVELS  = KEY_W / FIELD_W,
    parameter int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [KEY_W-1:0]  key,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic [PAY_W+1:0]  ram_rdata,
    output logic [KEY_W-1:0]  key_q,
    output logic [LVL_W-1:0]  lvl_next,
    output logic [ADDR_W-1:0] base,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              busy,
    output logic              hit,
    output logic [PAY_W-1:0]  group_id,
    output logic              miss,
    output logic [ADDR_W-1:0] miss_addr,
    output logic [LVL_W-1:0]  miss_level
);
    import walk_pkg::*;

    localparam logic [LVL_W-1:0] LAST = LVL_W'(LEVELS - 1);

    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_DECODE} st_e;

    st_e               state;
    logic [LVL_W-1:0]  lvl;
    logic [ADDR_W-1:0] rd_addr;
    ent_kind_e         kind;
    logic [PAY_W-1:0]  payload;

    assign kind     = ent_kind_e'(ram_rdata[PAY_W+1 -: 2]);
    assign payload  = ram_rdata[PAY_W-1:0];
    assign base     = payload[ADDR_W-1:0];
    assign lvl_next = lvl + LVL_W'(1);
    assign busy     = (state != ST_IDLE);

    // Table port: a write from outside when idle, otherwise the read of the walk.
    always_comb begin
        ram_we   = wr_en && (state == ST_IDLE);
        ram_en   = ram_we || (state == ST_READ);
        ram_addr = ram_we ? wr_addr : rd_addr;
    end

    // Walk state machine and the registered result outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            lvl        <= '0;
            rd_addr    <= '0;
            key_q      <= '0;
            hit        <= 1'b0;
            miss       <= 1'b0;
            group_id   <= '0;
            miss_addr  <= '0;
            miss_level <= '0;
        end else begin
            hit  <= 1'b0;
            miss <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (key_valid) begin
                        key_q   <= key;
                        lvl     <= '0;
                        rd_addr <= first_addr;
                        state   <= ST_READ;
                    end
                end
                ST_READ: begin
                    state <= ST_DECODE;
                end
                default: begin
                    if (kind == ENT_LEAF) begin
                        hit      <= 1'b1;
                        group_id <= payload;
                        state    <= ST_IDLE;
                    end else if (kind == ENT_NODE && lvl != LAST) begin
                        lvl     <= lvl_next;
                        rd_addr <= next_addr;
                        state   <= ST_READ;
                    end else begin
                        miss       <= 1'b1;
                        miss_addr  <= rd_addr;
                        miss_level <= lvl;
                        state      <= ST_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/group_tree_walker.sv
// Top level: finds the group of a key by walking a 2^FIELD_W-ary tree held in a table.
// Assumes PAY_W >= ADDR_W, so that a payload can hold a base index.
module group_tree_walker #(
    parameter int KEY_W   = 8,
    parameter int FIELD_W = 2,
    parameter int ADDR_W  = 8,
    parameter int PAY_W   = 12,
    parameter int LEVELS  = KEY_W / FIELD_W,
    parameter int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [KEY_W-1:0]  key,
    output logic              busy,
    output logic              hit,
    output logic [PAY_W-1:0]  group_id,
    output logic              miss,
    output logic [ADDR_W-1:0] miss_addr,
    output logic [LVL_W-1:0]  miss_level,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_kind,
    input  logic [PAY_W-1:0]  wr_payload
);
    localparam int DATA_W = PAY_W + 2;

    logic [KEY_W-1:0]  key_q;
    logic [LVL_W-1:0]  lvl_next;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] first_addr;
    logic [ADDR_W-1:0] next_addr;
    logic              ram_en;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_rdata;

    // Root lookup: implied base zero, level 0 field of the incoming key.
    walk_step #(.KEY_W(KEY_W), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W),
                .LEVELS(LEVELS), .LVL_W(LVL_W)) u_first (
        .key(key), .level('0), .base('0), .addr(first_addr)
    );

    // Deeper lookups: base from the decoded node, field of the next level.
    walk_step #(.KEY_W(KEY_W), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W),
                .LEVELS(LEVELS), .LVL_W(LVL_W)) u_next (
        .key(key_q), .level(lvl_next), .base(base), .addr(next_addr)
    );

    walk_ctrl #(.KEY_W(KEY_W), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W), .PAY_W(PAY_W),
                .LEVELS(LEVELS), .LVL_W(LVL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key(key),
        .wr_en(wr_en), .wr_addr(wr_addr), .first_addr(first_addr),
        .next_addr(next_addr), .ram_rdata(ram_rdata), .key_q(key_q),
        .lvl_next(lvl_next), .base(base), .ram_en(ram_en), .ram_we(ram_we),
        .ram_addr(ram_addr), .busy(busy), .hit(hit), .group_id(group_id),
        .miss(miss), .miss_addr(miss_addr), .miss_level(miss_level)
    );

    walk_table_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
        .wdata({wr_kind, wr_payload}), .rdata(ram_rdata)
    );
endmodule

// File: rtl/walk_chk.sv
// Protocol checker for group_tree_walker, attached with bind below.
// Assumes a synchronous active-low reset. It only watches the ports.
module walk_chk #(
    parameter int ADDR_W = 8,
    parameter int PAY_W  = 12,
    parameter int LEVELS = 4,
    parameter int LVL_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              key_valid,
    input logic              busy,
    input logic              hit,
    input logic [PAY_W-1:0]  group_id,
    input logic              miss,
    input logic [ADDR_W-1:0] miss_addr,
    input logic [LVL_W-1:0]  miss_level
);
    localparam int CW = $clog2(2 * LEVELS + 2) + 1;

    logic [CW-1:0] busy_run;

    // Count the busy cycles of the current walk.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_run <= '0;
        else if (busy) busy_run <= busy_run + CW'(1);
        else busy_run <= '0;
    end

    assert_one_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && miss));
    assert_pulse_short_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit || miss) |=> !(hit || miss));
    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && !busy) |=> busy);
    assert_result_ends_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit || miss) |-> (!busy && $past(busy)));
    assert_walk_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= CW'(2 * LEVELS));
    assert_group_on_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(group_id) |-> hit);
    assert_miss_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(miss_addr) || !$stable(miss_level)) |-> miss);
endmodule

bind group_tree_walker walk_chk #(
    .ADDR_W(ADDR_W), .PAY_W(PAY_W), .LEVELS(LEVELS), .LVL_W(LVL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .busy(busy), .hit(hit),
    .group_id(group_id), .miss(miss), .miss_addr(miss_addr), .miss_level(miss_level)
);

// File: tb/sim_group_tree_walker.sv
// Self-checking bench: a table of vectors, then a sweep of all keys against a model, then directed tests.
module sim_group_tree_walker;
    localparam int KEY_W = 8, FIELD_W = 2, ADDR_W = 8, PAY_W = 12, LEVELS = 4, LVL_W = 2;
    localparam int DEPTH = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic key_valid = 1'b0;
    logic [KEY_W-1:0] key = '0;
    logic busy, hit, miss;
    logic [PAY_W-1:0] group_id;
    logic [ADDR_W-1:0] miss_addr;
    logic [LVL_W-1:0] miss_level;
    logic wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [1:0] wr_kind = '0;
    logic [PAY_W-1:0] wr_payload = '0;

    int checks = 0;
    int fails  = 0;

    logic [1:0]       mdl_kind [DEPTH];
    logic [PAY_W-1:0] mdl_pay  [DEPTH];

    always #2 clk = ~clk;

    group_tree_walker u0 (
        .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key(key), .busy(busy),
        .hit(hit), .group_id(group_id), .miss(miss), .miss_addr(miss_addr),
        .miss_level(miss_level), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_kind(wr_kind), .wr_payload(wr_payload)
    );

    // Vector: {key, exp_hit, exp_value (handle or miss address), exp_level, lookups}
    localparam logic [25:0] VEC [0:13] = '{
        {8'h00, 1'b0, 12'h000, 2'd0, 3'd1},
        {8'h5A, 1'b1, 12'h0A1, 2'd0, 3'd1},
        {8'h80, 1'b1, 12'h123, 2'd0, 3'd2},
        {8'h90, 1'b0, 12'h011, 2'd1, 3'd2},
        {8'hA0, 1'b1, 12'h901, 2'd0, 3'd4},
        {8'hA1, 1'b0, 12'h041, 2'd3, 3'd4},
        {8'hA3, 1'b1, 12'hABC, 2'd0, 3'd4},
        {8'hA4, 1'b1, 12'h555, 2'd0, 3'd3},
        {8'hA8, 1'b0, 12'h032, 2'd2, 3'd3},
        {8'hB0, 1'b1, 12'h7FE, 2'd0, 3'd3},
        {8'hB8, 1'b0, 12'h000, 2'd2, 3'd3},
        {8'hBC, 1'b1, 12'h0A1, 2'd0, 3'd3},
        {8'hD0, 1'b1, 12'h321, 2'd0, 3'd2},
        {8'hC0, 1'b0, 12'h020, 2'd1, 3'd2}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Write one entry through the port; the model follows when upd is set.
    task automatic put(input int a, input logic [1:0] k, input int p, input bit upd);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_kind = k; wr_payload = PAY_W'(p);
        @(negedge clk);
        wr_en = 1'b0;
        if (upd) begin
            mdl_kind[a] = k;
            mdl_pay[a]  = PAY_W'(p);
        end
    endtask

    // Behavioural tree walk built from the requirements.
    function automatic void model_walk(input logic [KEY_W-1:0] k, output bit h,
                                       output int v, output int lv, output int n);
        logic [ADDR_W-1:0] b = '0;
        logic [ADDR_W-1:0] a;
        h = 0; v = 0; lv = 0; n = 0;
        for (int j = 0; j < LEVELS; j++) begin
            a = b + ADDR_W'(k[KEY_W-1-j*FIELD_W -: FIELD_W]);
            n = j + 1;
            if (mdl_kind[a] == 2'b10) begin
                h = 1; v = int'(mdl_pay[a]); return;
            end else if (mdl_kind[a] == 2'b01 && j != LEVELS - 1) begin
                b = mdl_pay[a][ADDR_W-1:0];
            end else begin
                h = 0; v = int'(a); lv = j; return;
            end
        end
    endfunction

    // Offer one key, then check the result, its latency and busy (R2, R8, R10).
    task automatic run_key(input logic [KEY_W-1:0] k, input bit eh, input int ev,
                           input int el, input int en, input string req);
        int  cyc = 0;
        bit  got = 0;
        @(negedge clk);
        key_valid = 1'b1; key = k;
        @(negedge clk);
        key_valid = 1'b0;
        check(busy === 1'b1, "R2", "busy after accept", int'(busy), 1);
        while (!got && cyc < 40) begin
            @(negedge clk);
            cyc++;
            if (hit || miss) got = 1;
            else if (!busy) check(1'b0, "R2", "busy dropped early", cyc, 2 * en);
        end
        check(cyc == 2 * en, "R8", "result latency", cyc, 2 * en);
        check(!(hit && miss), "R10", "hit and miss together", int'(hit & miss), 0);
        check(hit === eh, req, "hit flag", int'(hit), int'(eh));
        check(miss === !eh, req, "miss flag", int'(miss), int'(!eh));
        if (eh) begin
            check(int'(group_id) == ev, req, "group_id", int'(group_id), ev);
        end else begin
            check(int'(miss_addr) == ev, req, "miss_addr", int'(miss_addr), ev);
            check(int'(miss_level) == el, req, "miss_level", int'(miss_level), el);
        end
        check(!busy, "R8", "busy at result", int'(busy), 0);
        @(negedge clk);
        check(!hit && !miss, "R10", "pulse length", int'({hit, miss}), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog expired: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        bit h; int v, lv, n;
        int cnt;
        repeat (4) @(negedge clk);
        // R1: state held by reset
        check(!busy && !hit && !miss, "R1", "flags in reset", int'({busy, hit, miss}), 0);
        check(group_id == '0 && miss_addr == '0 && miss_level == '0, "R1", "fields in reset",
              int'(group_id) + int'(miss_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !hit && !miss, "R1", "flags after reset", int'({busy, hit, miss}), 0);

        // Empty table (R4: all ones is the no-match tag), then build the tree.
        for (int a = 0; a < DEPTH; a++) put(a, 2'b11, 12'hFFF, 1);
        put(8'h01, 2'b10, 12'h0A1, 1);
        put(8'h02, 2'b01, 12'h010, 1);
        put(8'h03, 2'b01, 12'h020, 1);
        put(8'h10, 2'b10, 12'h123, 1);
        put(8'h12, 2'b01, 12'h030, 1);
        put(8'h13, 2'b01, 12'h0FE, 1);
        put(8'hFE, 2'b10, 12'h7FE, 1);
        put(8'h30, 2'b01, 12'h040, 1);
        put(8'h31, 2'b10, 12'h555, 1);
        put(8'h40, 2'b10, 12'h901, 1);
        put(8'h42, 2'b01, 12'h050, 1);
        put(8'h43, 2'b10, 12'hABC, 1);
        put(8'h21, 2'b10, 12'h321, 1);
        put(8'h23, 2'b00, 12'h055, 1);

        // Vector table: addressing (R3) with hits (R5) and misses (R6).
        for (int i = 0; i < 14; i++) begin
            run_key(VEC[i][25:18], VEC[i][17], int'(VEC[i][16:5]), int'(VEC[i][4:3]),
                    int'(VEC[i][2:0]), VEC[i][17] ? "R3 R5" : "R3 R6");
        end

        // R7: internal node at the last level is a miss
        run_key(8'hA2, 1'b0, 12'h042, 3, 4, "R7");
        // R4: kind 2'b00 is empty
        run_key(8'hF0, 1'b0, 12'h023, 1, 2, "R4");

        // R3: sweep of every key against the model
        for (int k2 = 0; k2 < DEPTH; k2++) begin
            model_walk(KEY_W'(k2), h, v, lv, n);
            run_key(KEY_W'(k2), h, v, lv, n, "R3");
        end

        // R2: key_valid while busy is dropped
        @(negedge clk);
        key_valid = 1'b1; key = 8'hA0;
        @(negedge clk);
        key = 8'h5A;
        @(negedge clk);
        @(negedge clk);
        key_valid = 1'b0;
        cnt = 0;
        repeat (20) begin
            @(negedge clk);
            if (hit) begin
                cnt++;
                check(group_id == 12'h901, "R2", "first key result", int'(group_id), 12'h901);
            end
            if (miss) cnt = cnt + 10;
        end
        check(cnt == 1, "R2", "results for busy-time key", cnt, 1);

        // R9: write while busy is dropped; write while idle is seen
        @(negedge clk);
        key_valid = 1'b1; key = 8'hA0;
        @(negedge clk);
        key_valid = 1'b0;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h31; wr_kind = 2'b10; wr_payload = 12'h777;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (10) @(negedge clk);
        run_key(8'hA4, 1'b1, 12'h555, 0, 3, "R9");
        put(8'h31, 2'b10, 12'h777, 1);
        run_key(8'hA4, 1'b1, 12'h777, 0, 3, "R9");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule